// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a memory-mapped watchdog. An 8-bit up-counter advances once per prescaled tick. When it steps from 255 to 0 in watchdog mode, the block latches an overflow flag. If reset generation is armed, it also drives a reset request for a fixed number of clock cycles. Software keeps the system alive by reloading the counter before it wraps. The reload value sets the time left: loading 256 minus N leaves N ticks.

Three 16-bit word registers sit on a simple bus with an address, write strobe, read strobe, write data and combinational read data:

- control at offset 0;
- count at offset 2;
- reset control at offset 4.

A write changes state only when its upper byte carries the key for that register. Any other write is dropped without trace. The overflow flag is sticky. It clears only through a dedicated write value, and only if software has first read the reset-control register while the flag was set. This stops a single stray store from hiding a past overflow.

The prescaler divides the input clock by a power of two chosen by a select field. Its width is set by a parameter: 3 bits or 4 bits. Clearing the enable bit stops counting and zeroes the prescaler.

Top module: `kwdt_top`

## Requirements
- R1: After reset, all three registers read 0x0000 and `rst_req` is low.
- R2: Writing to offset 0 with upper byte 0xA5 loads three fields from the lower byte: watchdog mode from bit 6, timer enable from bit 5, and divider select from bits [SEL_W-1:0]. A read of offset 0 returns those fields in the same positions, with every other bit zero.
- R3: Writing to offset 2 with upper byte 0x5A loads the lower byte as the count. A read of offset 2 returns the count in bits 7:0 and zero in bits 15:8.
- R4: A write whose upper byte is not the key of the addressed register changes no register. This holds for all three registers.
- R5: While the enable bit is 1, the count rises by one on each prescaled tick. While the enable bit is 0, the count holds.
- R6: Select codes 0 to 7 divide the clock by 1, 64, 128, 256, 512, 1024, 4096 and 16384. With 4-bit selects, codes 8 to 15 divide by 2^15 to 2^22. If the count is loaded with 256-N while the timer is stopped and the timer is then enabled with divider D, the count wraps to 0 exactly N*D clock cycles after the enabling write.
- R7: A wrap in watchdog mode sets the overflow flag, which reads as bit 7 of offset 4. The count continues from 0.
- R8: Writing to offset 4 with upper byte 0x5A loads the reset-enable bit from bit 6. The bit reads back at bit 6. A watchdog-mode wrap with reset enabled drives `rst_req` high for exactly 16 cycles, starting at the wrap edge. With reset disabled, `rst_req` stays low.
- R9: Writing 0xA500 to offset 4 clears the overflow flag only if offset 4 was read, with the read strobe, while the flag was set. Otherwise the flag stays set.
- R10: In interval mode (bit 6 of offset 0 is 0), a wrap sets no flag and raises no reset request.
- R11: Clearing the enable bit zeroes the prescaler. After re-enabling, the first tick comes a full D cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag-clear sequence) |
| bus_wdata | input | 16 | Write data: key in 15:8, value in 7:0 |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | Reset request pulse |

## Verification
Overflow timing is checked for every 3-bit divider code using a two-tick reload. The flag is sampled one cycle before and at the predicted wrap edge, so an off-by-one in the prescaler or the divider table is caught.

Key handling is checked by sending each register the key of another register. The clear sequence is checked three ways: without the arming read, with a clear value that is wrong, and after a proper read. This separates the rule that a read must come first from plain key matching.

Two further cases isolate the remaining behaviours. One wraps in interval mode, which separates mode gating from reset enable. The other stops and restarts the prescaler mid-period, which shows whether it restarts from zero.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam logic [7:0] KEY_CTRL  = 8'hA5;
    localparam logic [7:0] KEY_LOAD  = 8'h5A;
    localparam logic [15:0] FLAG_CLR = 16'hA500;

    localparam int OFS_CTRL = 0;
    localparam int OFS_CNT  = 2;
    localparam int OFS_RSTC = 4;

    localparam int BIT_WDMODE = 6;
    localparam int BIT_EN     = 5;
    localparam int BIT_RSTEN  = 6;
    localparam int BIT_FLAG   = 7;

    typedef struct packed {
        logic       wd_mode;
        logic       run;
        logic [3:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic ctrl_we;
        logic cnt_we;
        logic rstc_we;
        logic clr_try;
        logic rd_rstc;
    } bus_dec_t;

    // log2 of the division ratio for a select code
    function automatic int div_shift(input logic [3:0] code, input int sel_w);
        int s;
        if (sel_w == 4 && code[3]) begin
            s = 15 + int'(code[2:0]);
        end else begin
            case (code[2:0])
                3'd0: s = 0;
                3'd1: s = 6;
                3'd2: s = 7;
                3'd3: s = 8;
                3'd4: s = 9;
                3'd5: s = 10;
                3'd6: s = 12;
                default: s = 14;
            endcase
        end
        return s;
    endfunction

    function automatic int pre_width(input int sel_w);
        return (sel_w == 4) ? 22 : 14;
    endfunction

endpackage

// File: rtl/kwdt_regbank.sv
module kwdt_regbank
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    input  logic [7:0]        cnt_val,
    input  logic              ovf_set,
    output logic [15:0]       bus_rdata,
    output ctrl_t             ctrl,
    output logic              cnt_we,
    output logic              rst_en,
    output logic              ovf_flag,
    output logic              clr_armed
);

    bus_dec_t dec;
    logic [7:0] key;
    logic       clr_ok;

    assign key = bus_wdata[15:8];

    always_comb begin
        dec         = '0;
        dec.ctrl_we = bus_wr && (int'(bus_addr) == OFS_CTRL) && (key == KEY_CTRL);
        dec.cnt_we  = bus_wr && (int'(bus_addr) == OFS_CNT)  && (key == KEY_LOAD);
        dec.rstc_we = bus_wr && (int'(bus_addr) == OFS_RSTC) && (key == KEY_LOAD);
        dec.clr_try = bus_wr && (int'(bus_addr) == OFS_RSTC) && (bus_wdata == FLAG_CLR);
        dec.rd_rstc = bus_rd && (int'(bus_addr) == OFS_RSTC);
    end

    assign cnt_we = dec.cnt_we;
    assign clr_ok = dec.clr_try && clr_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (dec.ctrl_we) begin
            ctrl.wd_mode <= bus_wdata[BIT_WDMODE];
            ctrl.run     <= bus_wdata[BIT_EN];
            ctrl.sel     <= 4'(bus_wdata[SEL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_en <= 1'b0;
        end else if (dec.rstc_we) begin
            rst_en <= bus_wdata[BIT_RSTEN];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag  <= 1'b0;
            clr_armed <= 1'b0;
        end else begin
            if (ovf_set) begin
                ovf_flag <= 1'b1;
            end else if (clr_ok) begin
                ovf_flag <= 1'b0;
            end
            if (clr_ok) begin
                clr_armed <= 1'b0;
            end else if (dec.rd_rstc && ovf_flag) begin
                clr_armed <= 1'b1;
            end
        end
    end

    logic [7:0] ctrl_rd;
    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[BIT_WDMODE]  = ctrl.wd_mode;
        ctrl_rd[BIT_EN]      = ctrl.run;
        ctrl_rd[SEL_W-1:0]   = ctrl.sel[SEL_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            OFS_CTRL: bus_rdata[7:0] = ctrl_rd;
            OFS_CNT:  bus_rdata[7:0] = cnt_val;
            OFS_RSTC: begin
                bus_rdata[BIT_FLAG]  = ovf_flag;
                bus_rdata[BIT_RSTEN] = rst_en;
            end
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
    import kwdt_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [3:0] sel,
    output logic       tick
);

    localparam int PRE_W = pre_width(SEL_W);
    localparam int SH_W  = $clog2(PRE_W + 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [SH_W-1:0]  shamt;

    assign shamt = SH_W'(div_shift(sel, SEL_W));
    assign mask  = ~({PRE_W{1'b1}} << shamt);
    assign tick  = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = tick && !load && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_rstgen.sv
module kwdt_rstgen #(
    parameter int PULSE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic req
);

    localparam int PW = $clog2(PULSE + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (trig) begin
            left_q <= PW'(PULSE);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign req = (left_q != '0);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int SEL_W  = 3,
    parameter int PULSE  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              rst_req
);

    localparam int CNT_W = 8;

    ctrl_t            ctrl;
    logic             cnt_we;
    logic             rst_en;
    logic             ovf_flag;
    logic             clr_armed;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt_val;
    logic             ovf_ev;

    assign ovf_ev = wrap && ctrl.wd_mode;

    kwdt_regbank #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_val),
        .ovf_set   (ovf_ev),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .cnt_we    (cnt_we),
        .rst_en    (rst_en),
        .ovf_flag  (ovf_flag),
        .clr_armed (clr_armed)
    );

    kwdt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .restart (cnt_we),
        .sel     (ctrl.sel),
        .tick    (tick)
    );

    kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_we),
        .load_val (bus_wdata[CNT_W-1:0]),
        .tick     (tick),
        .cnt      (cnt_val),
        .wrap     (wrap)
    );

    kwdt_rstgen #(.PULSE(PULSE)) u_rgen (
        .clk  (clk),
        .rst  (rst),
        .trig (ovf_ev && rst_en),
        .req  (rst_req)
    );

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int PULSE  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              rst_req,
    input logic [7:0]        cnt_val,
    input logic              tick,
    input logic              wrap,
    input logic              wd_mode,
    input logic              run,
    input logic [3:0]        sel,
    input logic              rst_en,
    input logic              ovf_flag,
    input logic              clr_armed
);

    localparam int HW = $clog2(PULSE + 2);
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rst_req) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (int'(hi_cnt) < PULSE));

    assert_pulse_full_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && $past(rst_req)) |-> (int'($past(hi_cnt)) == PULSE - 1));

    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(wrap && wd_mode && rst_en));

    assert_interval_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (wrap && !wd_mode && !ovf_flag) |=> !ovf_flag);

    assert_flag_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (wrap && wd_mode) |=> ovf_flag);

    assert_clear_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(clr_armed && bus_wr && (int'(bus_addr) == OFS_RSTC)
                                  && (bus_wdata == FLAG_CLR)));

    assert_badkey_cnt_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (int'(bus_addr) == OFS_CNT) && (bus_wdata[15:8] != KEY_LOAD) && !tick)
        |=> $stable(cnt_val));

    assert_badkey_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (int'(bus_addr) == OFS_CTRL) && (bus_wdata[15:8] != KEY_CTRL))
        |=> ($stable(wd_mode) && $stable(run) && $stable(sel)));

    assert_halt_R5: assert property (@(posedge clk) disable iff (rst)
        (!run && !(bus_wr && (int'(bus_addr) == OFS_CNT) && (bus_wdata[15:8] == KEY_LOAD)))
        |=> $stable(cnt_val));

    assert_key_byte_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == OFS_CTRL || int'(bus_addr) == OFS_CNT) |-> (bus_rdata[15:8] == 8'h00));

endmodule

bind kwdt_top kwdt_checker #(.ADDR_W(ADDR_W), .PULSE(PULSE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req),
    .cnt_val   (cnt_val),
    .tick      (tick),
    .wrap      (wrap),
    .wd_mode   (ctrl.wd_mode),
    .run       (ctrl.run),
    .sel       (ctrl.sel),
    .rst_en    (rst_en),
    .ovf_flag  (ovf_flag),
    .clr_armed (clr_armed)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    kwdt_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        #0.5 v = bus_rdata;
    endtask

    task automatic clear_flag();
        logic [15:0] v;
        bus_read(3'd4, v);
        bus_write(3'd4, 16'hA500);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(3'd0, v); chk("R1 ctrl", v, 16'h0000);
        peek(3'd2, v); chk("R1 cnt", v, 16'h0000);
        peek(3'd4, v); chk("R1 rstc", v, 16'h0000);
        chk("R1 rst_req", {15'd0, rst_req}, 16'h0000);
    endtask

    task automatic t_ctrl_rw();
        logic [15:0] v;
        bus_write(3'd0, 16'hA5D7);
        peek(3'd0, v); chk("R2 fields", v, 16'h0047);
        bus_write(3'd0, 16'hA503);
        peek(3'd0, v); chk("R2 sel only", v, 16'h0003);
    endtask

    task automatic t_cnt_rw();
        logic [15:0] v;
        bus_write(3'd2, 16'h5A3C);
        peek(3'd2, v); chk("R3 load", v, 16'h003C);
    endtask

    task automatic t_bad_key();
        logic [15:0] v;
        bus_write(3'd0, 16'h5A65);
        peek(3'd0, v); chk("R4 ctrl bad key", v, 16'h0003);
        bus_write(3'd2, 16'hA511);
        peek(3'd2, v); chk("R4 cnt bad key", v, 16'h003C);
        bus_write(3'd4, 16'hA540);
        peek(3'd4, v); chk("R4 rstc bad key", v, 16'h0000);
    endtask

    task automatic t_rste_rw();
        logic [15:0] v;
        bus_write(3'd4, 16'h5A40);
        peek(3'd4, v); chk("R8 rsten readback", v, 16'h0040);
        bus_write(3'd4, 16'h5A00);
        peek(3'd4, v); chk("R8 rsten off", v, 16'h0000);
    endtask

    task automatic t_rate();
        logic [15:0] v;
        bus_write(3'd2, 16'h5A10);
        bus_write(3'd0, 16'hA521);           // interval mode, run, /64
        cyc(3 * 64 - 1);
        peek(3'd2, v); chk("R5 before third tick", v, 16'h0012);
        cyc(1);
        peek(3'd2, v); chk("R5 third tick", v, 16'h0013);
        bus_write(3'd0, 16'hA501);           // stop
        peek(3'd2, v);
        begin
            logic [15:0] held;
            held = v;
            cyc(200);
            peek(3'd2, v); chk("R5 halted holds", v, held);
        end
    endtask

    task automatic t_overflow_all();
        logic [15:0] v;
        for (int code = 0; code < 8; code++) begin
            int d;
            case (code)
                0: d = 1;    1: d = 64;   2: d = 128;  3: d = 256;
                4: d = 512;  5: d = 1024; 6: d = 4096; default: d = 16384;
            endcase
            bus_write(3'd2, 16'h5AFE);       // N = 2
            bus_write(3'd0, 16'hA560 | 16'(code));
            cyc(2 * d - 1);
            peek(3'd4, v); chk($sformatf("R6 code %0d before wrap", code), v, 16'h0000);
            cyc(1);
            peek(3'd4, v); chk($sformatf("R7 code %0d flag", code), v, 16'h0080);
            peek(3'd2, v); chk($sformatf("R7 code %0d wrapped", code), v, 16'h0000);
            chk("R8 no pulse when disabled", {15'd0, rst_req}, 16'h0000);
            bus_write(3'd0, 16'hA500);
            clear_flag();
            peek(3'd4, v); chk("R9 clear after read", v, 16'h0000);
        end
    endtask

    task automatic t_clear_seq();
        logic [15:0] v;
        bus_write(3'd2, 16'h5AFF);
        bus_write(3'd0, 16'hA560);
        cyc(2);
        bus_write(3'd0, 16'hA500);
        peek(3'd4, v); chk("R7 flag set", v, 16'h0080);
        bus_write(3'd4, 16'hA500);
        peek(3'd4, v); chk("R9 no read no clear", v, 16'h0080);
        bus_read(3'd4, v);
        bus_write(3'd4, 16'hA501);
        peek(3'd4, v); chk("R9 wrong clear value", v, 16'h0080);
        bus_write(3'd4, 16'hA500);
        peek(3'd4, v); chk("R9 armed clear", v, 16'h0000);
    endtask

    task automatic t_pulse();
        logic [15:0] v;
        bus_write(3'd4, 16'h5A40);
        bus_write(3'd2, 16'h5AFF);
        bus_write(3'd0, 16'hA560);
        chk("R8 low before wrap", {15'd0, rst_req}, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            cyc(1);
            chk($sformatf("R8 pulse cycle %0d", i), {15'd0, rst_req}, 16'h0001);
        end
        cyc(1);
        chk("R8 pulse ended", {15'd0, rst_req}, 16'h0000);
        bus_write(3'd0, 16'hA500);
        clear_flag();
    endtask

    task automatic t_interval();
        logic [15:0] v;
        bus_write(3'd2, 16'h5AFF);
        bus_write(3'd0, 16'hA520);           // interval, run, /1, reset still enabled
        cyc(1);
        bus_write(3'd0, 16'hA500);
        peek(3'd2, v); chk("R10 counter wrapped", v, 16'h0002);
        peek(3'd4, v); chk("R10 no flag", v, 16'h0040);
        cyc(20);
        chk("R10 no reset request", {15'd0, rst_req}, 16'h0000);
        bus_write(3'd4, 16'h5A00);
    endtask

    task automatic t_prescaler_restart();
        logic [15:0] v;
        bus_write(3'd2, 16'h5A00);
        bus_write(3'd0, 16'hA521);
        cyc(40);
        bus_write(3'd0, 16'hA501);
        cyc(5);
        bus_write(3'd0, 16'hA521);
        cyc(63);
        peek(3'd2, v); chk("R11 no early tick", v, 16'h0000);
        cyc(1);
        peek(3'd2, v); chk("R11 tick after full period", v, 16'h0001);
        bus_write(3'd0, 16'hA500);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_rw();
        t_cnt_rw();
        t_bad_key();
        t_rste_rw();
        t_rate();
        t_overflow_all();
        t_clear_seq();
        t_pulse();
        t_interval();
        t_prescaler_restart();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule